// File: doc/BRIEF.md
# Asynchronous SRAM Write-Strobe Controller

This block connects a synchronous processor memory port to an external asynchronous static RAM. Each processor cycle carries at most one request. The block registers the address and write data at the cycle boundary and holds them for the whole cycle. It drives an active-low output enable during reads and an active-low write enable during writes. The data bus is split into an output, an input and a drive-enable, so the pad can be placed one level up in the chip.

The write strobe must be narrower than a processor cycle. The address and data then settle before the strobe falls and stay put after it rises. A second clock runs at twice the processor rate, with its rising edges aligned to the processor clock. A register on the falling edge of that fast clock loads the AND of the current cycle's write flag with the inverse of its own value. The pin carries the inverse of that register. Each write cycle therefore gets exactly one low pulse, one fast period wide, centred in the cycle.

When a read is followed at once by a write, output enable rises at the boundary. The read data is latched on that same edge. The block drives the bus only from the next fast falling edge, half a fast period later, so the memory has time to release the bus.

Top module: `sram_strobe_if`

## Requirements
- R1: While reset is high and after its release: write enable high, output enable high, drive enable low, read-valid low.
- R2: A request (cpu_req=1) is taken at a rising processor edge. Its address appears on sram_addr, and for a write its data appears on sram_dq_o. Both are held steady throughout the write strobe.
- R3: A write cycle gives one low pulse on sram_we_n. The pulse falls at the first fast falling edge after the cycle starts, i.e. half a fast period in. It lasts exactly one fast period.
- R4: Back-to-back writes each get their own pulse. The strobe is high at every processor edge, and the number of pulses equals the number of writes.
- R5: sram_oe_n is low during exactly the cycle that follows a read request and high otherwise, including in write cycles.
- R6: sram_dq_t (1 = block drives the bus) is high during a write cycle from its first fast falling edge to its end. It is never high while sram_oe_n is low.
- R7: Read data is latched at the end of the read cycle. It is shown on cpu_rdata with cpu_rvalid high during the next cycle.
- R8: On a read followed directly by a write, output enable is high and the drive enable low just after the boundary. Driving starts half a fast period later.
- R9: sram_oe_n and sram_we_n are never low together.
- R10: With cpu_req low, cpu_wr and the other request inputs are ignored. There is no strobe, no output enable and no drive, and sram_addr keeps its previous value.
- R11: Data written through the strobe is returned by a later read of the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| clk2x | input | 1 | Twice-rate clock, rising edges aligned with clk |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Request valid this cycle |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Request address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, one cycle after the read cycle |
| cpu_rvalid | output | 1 | cpu_rdata valid |
| sram_addr | output | ADDR_W | SRAM address |
| sram_dq_o | output | DATA_W | Data driven to the SRAM |
| sram_dq_t | output | 1 | Data bus drive enable, active high |
| sram_dq_i | input | DATA_W | Data read from the SRAM bus |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |

## Verification
A request placed before processor edge k is accepted on that edge. Its address, output enable and the low drive enable are checked 3 ns later. The strobe fall and the drive start come 2 ns after k, so the same 3 ns sample sees them. Read data is due after edge k+1.

The bench carries each stimulus through a two-stage pipeline of expected values. It checks each result at exactly that offset from the edge that produces it. A monitor timestamps every strobe edge against the latest processor edge, which checks the 2 ns offset and the 4 ns width. The turnaround gap is sampled 1 ns after the boundary.

// File: rtl/sram_strobe_pkg.sv
package sram_strobe_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_kind_e;
endpackage

// File: rtl/sram_req_stage.sv
module sram_req_stage
  import sram_strobe_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output cyc_kind_e         kind,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q
);
  // Request capture: the address and data stay constant for the whole cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      kind    <= CYC_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      if (!cpu_req)    kind <= CYC_IDLE;
      else if (cpu_wr) kind <= CYC_WRITE;
      else             kind <= CYC_READ;
      if (cpu_req) addr_q <= cpu_addr;
      if (cpu_req && cpu_wr) wdata_q <= cpu_wdata;
    end
  end
endmodule

// File: rtl/sram_we_shaper.sv
module sram_we_shaper (
  input  logic clk,
  input  logic clk2x,
  input  logic rst,
  input  logic wr_cyc,
  output logic we_n
);
  logic strobe;

  // Toggle on the fast falling edge: it sets at the cycle's quarter point and
  // clears one fast period later, so the strobe never crosses a boundary.
  always_ff @(negedge clk2x) begin
    if (rst) strobe <= 1'b0;
    else     strobe <= wr_cyc & ~strobe;
  end

  assign we_n = ~strobe;

  // R3
  strobe_in_write_chk: assert property (@(posedge clk2x) disable iff (rst)
    strobe |-> wr_cyc);
  // R4
  strobe_idle_at_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe);
endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
  import sram_strobe_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              clk2x,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_wr,
  input  cyc_kind_e         kind,
  input  logic [DATA_W-1:0] dq_i,
  output logic              oe_n,
  output logic              dq_t,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic drv_q;
  logic wr_now;

  assign wr_now = (kind == CYC_WRITE);

  // The output enable is registered from the request itself, so it rises
  // exactly at the boundary that leaves a read cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      oe_n   <= 1'b1;
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      oe_n   <= ~(cpu_req & ~cpu_wr);
      rvalid <= (kind == CYC_READ);
      if (kind == CYC_READ) rdata <= dq_i;
    end
  end

  // Drive starts on the first fast falling edge of a write cycle. It is gated
  // by the cycle kind so that it stops at the boundary.
  always_ff @(negedge clk2x) begin
    if (rst) drv_q <= 1'b0;
    else     drv_q <= wr_now;
  end

  assign dq_t = drv_q & wr_now;

  // R6
  no_drive_with_oe_chk: assert property (@(posedge clk2x) disable iff (rst)
    dq_t |-> oe_n);
  // R5
  oe_high_on_write_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && cpu_wr) |=> oe_n);
endmodule

// File: rtl/sram_strobe_if.sv
module sram_strobe_if
  import sram_strobe_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              clk2x,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_rvalid,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_t,
  input  logic [DATA_W-1:0] sram_dq_i,
  output logic              sram_oe_n,
  output logic              sram_we_n
);
  cyc_kind_e         kind;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              wr_cyc;

  sram_req_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_wr(cpu_wr),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .kind(kind), .addr_q(addr_q), .wdata_q(wdata_q)
  );

  assign wr_cyc = (kind == CYC_WRITE);

  sram_we_shaper u_we (
    .clk(clk), .clk2x(clk2x), .rst(rst), .wr_cyc(wr_cyc), .we_n(sram_we_n)
  );

  sram_bus_ctrl #(.DATA_W(DATA_W)) u_bus (
    .clk(clk), .clk2x(clk2x), .rst(rst), .cpu_req(cpu_req), .cpu_wr(cpu_wr),
    .kind(kind), .dq_i(sram_dq_i), .oe_n(sram_oe_n), .dq_t(sram_dq_t),
    .rdata(cpu_rdata), .rvalid(cpu_rvalid)
  );

  assign sram_addr = addr_q;
  assign sram_dq_o = wdata_q;

  // R9
  oe_we_excl_chk: assert property (@(posedge clk2x) disable iff (rst)
    sram_oe_n || sram_we_n);
  // R7
  read_valid_due_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && !cpu_wr) |-> ##2 cpu_rvalid);
  // R10
  idle_no_oe_chk: assert property (@(posedge clk) disable iff (rst)
    !cpu_req |=> sram_oe_n && !sram_dq_t);
endmodule

// File: tb/test_sram_strobe_if.sv
`timescale 1ns/1ps
module test_sram_strobe_if;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int NV = 16;
  localparam int DEPTH = 1 << AW;
  // {req, wr, addr[5:0], wdata[15:0]}
  localparam logic [23:0] VEC [NV] = '{
    24'hC51111, 24'hC62222, 24'h850000, 24'h860000,
    24'h000000, 24'hC53333, 24'h850000, 24'h870000,
    24'hC74444, 24'h870000, 24'h7FFFFF, 24'h890000,
    24'hC95555, 24'hCA6666, 24'h8A0000, 24'h890000
  };

  typedef struct packed {
    logic          req;
    logic          wr;
    logic [AW-1:0] addr;
    logic [DW-1:0] exp;
  } op_t;

  logic clk = 0, clk2x = 0, rst = 1;
  logic cpu_req = 0, cpu_wr = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [DW-1:0] cpu_rdata, sram_dq_o, sram_dq_i;
  logic cpu_rvalid, sram_dq_t, sram_oe_n, sram_we_n;
  logic [AW-1:0] sram_addr;

  logic [DW-1:0] sram_mem [DEPTH];
  logic [DW-1:0] shadow [DEPTH];
  int n_chk = 0, n_err = 0, pulses = 0, writes = 0;
  logic armed = 0, fall_seen = 0;
  realtime t_edge = 0.0, t_fall = 0.0;
  logic [AW-1:0] a_fall;
  logic [DW-1:0] d_fall;

  always #2 clk2x = ~clk2x;
  always @(posedge clk2x) clk <= ~clk;
  always @(posedge clk) t_edge = $realtime;

  assign sram_dq_i = sram_oe_n ? 16'hBAD0 : sram_mem[sram_addr];

  sram_strobe_if #(.ADDR_W(AW), .DATA_W(DW)) i_sram_strobe_if (
    .clk(clk), .clk2x(clk2x), .rst(rst), .cpu_req(cpu_req), .cpu_wr(cpu_wr),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_rvalid(cpu_rvalid), .sram_addr(sram_addr), .sram_dq_o(sram_dq_o),
    .sram_dq_t(sram_dq_t), .sram_dq_i(sram_dq_i), .sram_oe_n(sram_oe_n),
    .sram_we_n(sram_we_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Strobe monitor: pulse position, width and hold of address and data
  always @(negedge sram_we_n) if (armed) begin
    t_fall = $realtime; a_fall = sram_addr; d_fall = sram_dq_o; fall_seen = 1;
    chk("R3 fall offset", ((t_fall - t_edge) > 1.99 && (t_fall - t_edge) < 2.01), 1);
    chk("R6 drive at strobe", {sram_dq_t, sram_oe_n}, 2'b11);
  end
  always @(posedge sram_we_n) if (armed && fall_seen) begin
    fall_seen = 0;
    pulses++;
    chk("R3 width", (($realtime - t_fall) > 3.99 && ($realtime - t_fall) < 4.01), 1);
    chk("R2 addr held", sram_addr, a_fall);
    chk("R2 data held", sram_dq_o, d_fall);
    sram_mem[sram_addr] = sram_dq_o;
  end
  // R9 and R6: watch for overlap on every fast edge
  always @(clk2x) if (armed) begin
    if (!sram_oe_n && !sram_we_n) chk("R9 oe/we overlap", 1, 0);
    if (!sram_oe_n && sram_dq_t) chk("R6 contention", 1, 0);
  end

  initial begin
    #(200000 * 8);
    chk("watchdog", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    op_t pend, p1, p2;
    logic [AW-1:0] last_addr;
    for (int a = 0; a < DEPTH; a++) begin
      sram_mem[a] = DW'(a * 16'h0123) ^ 16'hA55A;
      shadow[a]   = DW'(a * 16'h0123) ^ 16'hA55A;
    end
    pend = '0; p1 = '0; p2 = '0; last_addr = '0;
    repeat (3) @(posedge clk);
    #3;
    chk("R1 we_n in reset", sram_we_n, 1);
    chk("R1 oe_n in reset", sram_oe_n, 1);
    chk("R1 dq_t in reset", sram_dq_t, 0);
    chk("R1 rvalid in reset", cpu_rvalid, 0);
    #2 rst = 0;
    @(posedge clk); #3;
    armed = 1;
    chk("R1 idle after reset", {sram_we_n, sram_oe_n, sram_dq_t, cpu_rvalid}, 4'b1100);
    #2;
    for (int i = 0; i < NV + 2; i++) begin
      logic [23:0] v;
      @(posedge clk); #1;
      // R8: turnaround gap right after a read->write boundary
      if (pend.req && pend.wr && p1.req && !p1.wr)
        chk("R8 gap", {sram_oe_n, sram_dq_t}, 2'b10);
      #2;
      p2 = p1; p1 = pend;
      chk("R7 rvalid", cpu_rvalid, p2.req && !p2.wr);
      if (p2.req && !p2.wr) chk("R7/R11 rdata", cpu_rdata, p2.exp);
      chk("R5 oe_n", sram_oe_n, !(p1.req && !p1.wr));
      chk("R6 dq_t", sram_dq_t, p1.req && p1.wr);
      chk("R3 we_n", sram_we_n, !(p1.req && p1.wr));
      if (p1.req) begin
        chk("R2 addr", sram_addr, p1.addr);
        last_addr = p1.addr;
      end else chk("R10 addr hold", sram_addr, last_addr);
      if (p1.req && p1.wr) chk("R2 wdata", sram_dq_o, p1.exp);
      #2;
      v = (i < NV) ? VEC[i] : 24'h0;
      cpu_req = v[23]; cpu_wr = v[22]; cpu_addr = v[21:16]; cpu_wdata = v[15:0];
      pend.req = v[23]; pend.wr = v[22]; pend.addr = v[21:16];
      if (v[23] && v[22]) begin
        shadow[v[21:16]] = v[15:0];
        pend.exp = v[15:0];
        writes++;
      end else pend.exp = shadow[v[21:16]];
    end
    @(posedge clk); #3;
    chk("R4 pulse count", pulses, writes);
    chk("R10 final idle", {sram_we_n, sram_oe_n, sram_dq_t}, 3'b110);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule